// File: doc/BRIEF.md
# Debug Mailbox with Per-Direction Overrun Detection

This block lets an external debugger and an on-chip processor trade 32-bit words through a pair of single-word slots. The debugger pushes request words into the block. The processor picks those words up, and writes its answers back, through a small register port. Answers leave the block toward the debugger on a valid/ready stream. Both sides run on one clock.

A control/status word records the state of the exchange. It shows whether a request is still unread and whether a resynchronization has been asked for. It also holds a sticky overrun flag for each direction, so a lost word is visible whichever way it travelled. The same word carries a self-clearing soft reset and a chip-reset request. The chip-reset request only drives a one-cycle pulse out of the block.

The mailbox has its own reset domain. Only the power-on/brown-out reset input or its own soft reset can clear it, so it keeps its contents across the chip reset it requests.

Stream rules:
- The request input is never back-pressured: `dbg_req_ready` is always high, and a word arriving over an unread one replaces it.
- On the answer output, `ret_valid` and `ret_data` stay stable until the cycle in which `ret_ready` is high.

Top module: `dbg_mailbox`

## Requirements
- R1: A request beat (`dbg_req_valid`) stores `dbg_req_data` and sets the pending flag (status bit 1) at the next edge. A bus read of address 0 returns the stored word and clears pending. If a read and a new beat fall in the same cycle, the read returns the old word and pending stays set.
- R2: A request beat that arrives while pending is set, with no read of address 0 in that cycle, replaces the stored word and sets the debugger-overrun flag (status bit 2).
- R3: A bus write to address 1 loads the answer word and raises `ret_valid`. `ret_valid` and `ret_data` hold until a cycle with `ret_ready` high, after which `ret_valid` falls unless a new write lands in that same cycle.
- R4: A bus write to address 1 while `ret_valid` is high and `ret_ready` is low sets the processor-overrun flag (status bit 3) and replaces the answer word.
- R5: Both overrun flags are sticky. A bus write to address 2 with a one in the flag's bit clears it. A new overrun in the same cycle wins over the clear.
- R6: A `dbg_resync` pulse sets status bit 0. A bus write to address 2 with bit 0 set clears it.
- R7: Writing a one to bit 4 of address 2 clears all mailbox state (stored words, pending, `ret_valid`, all flags) at the next edge. Bit 4 always reads as zero.
- R8: Writing a one to bit 5 of address 2 raises `chip_rst_req` for exactly the next cycle. Mailbox state is unchanged by this pulse, and bit 5 reads as zero.
- R9: `por_rst_n` low clears all state asynchronously. Status bits 31:6 always read as zero, and `dbg_status` mirrors the word read at address 2.
- R10: Bus reads of address 1 return the current answer word, and reads of address 3 return zero. Writes to addresses 0 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| por_rst_n | input | 1 | Power-on/brown-out reset, active low, asynchronous |
| dbg_req_valid | input | 1 | Debugger request beat |
| dbg_req_ready | output | 1 | Always high; requests are never stalled |
| dbg_req_data | input | 32 | Debugger request word |
| dbg_resync | input | 1 | Debugger resynchronization request pulse |
| ret_valid | output | 1 | Answer word available to the debugger |
| ret_ready | input | 1 | Debugger takes the answer word |
| ret_data | output | 32 | Answer word |
| bus_sel | input | 1 | Processor register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 request, 1 answer, 2 control/status, 3 unused |
| bus_wdata | input | 32 | Processor write data |
| bus_rdata | output | 32 | Processor read data, combinational from current state |
| dbg_status | output | 32 | Control/status word seen by the debugger |
| chip_rst_req | output | 1 | One-cycle chip reset request |

## Verification
The request slot is swept over all eight combinations of a prior unread word, a new beat and a processor read in the same cycle. This separates plain acceptance, replacement with overrun, and the race where a read and a write coincide. The answer slot gets the same sweep over a held word, a new write and `ret_ready`, which separates handover, overwrite with overrun, and write-during-handover. Flag clearing is then tried alone and racing a fresh overrun, and the reset controls are applied while state is live, so that the chip-reset pulse can be told apart from the soft reset that really clears the block.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_REQ  = 2'd0,
    REG_RET  = 2'd1,
    REG_CSR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CSR_RESYNC = 0;
  localparam int unsigned CSR_PEND   = 1;
  localparam int unsigned CSR_DOVR   = 2;
  localparam int unsigned CSR_AOVR   = 3;
  localparam int unsigned CSR_SRST   = 4;
  localparam int unsigned CSR_CRST   = 5;
  localparam int unsigned CSR_USED   = 6;
endpackage

// File: rtl/dbgmb_req_slot.sv
module dbgmb_req_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         ovr_w1c,
  output logic [W-1:0] word,
  output logic         pending,
  output logic         ovr
);
  logic lost;
  assign lost = push & pending & ~pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      pending <= 1'b0;
      ovr     <= 1'b0;
    end else if (clr) begin
      word    <= '0;
      pending <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (push) word <= push_data;
      pending <= push | (pending & ~pop);
      if (lost)         ovr <= 1'b1;
      else if (ovr_w1c) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/dbgmb_ret_slot.sv
module dbgmb_ret_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  input  logic         ovr_w1c,
  output logic [W-1:0] word,
  output logic         valid,
  output logic         ovr
);
  logic handed, lost;
  assign handed = valid & take;
  assign lost   = load & valid & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
      ovr   <= 1'b0;
    end else if (clr) begin
      word  <= '0;
      valid <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (load) word <= load_data;
      valid <= load | (valid & ~handed);
      if (lost)         ovr <= 1'b1;
      else if (ovr_w1c) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/dbgmb_ctrl.sv
module dbgmb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic resync_set,
  input  logic resync_w1c,
  input  logic crst_wr,
  output logic resync,
  output logic crst_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resync     <= 1'b0;
      crst_pulse <= 1'b0;
    end else begin
      crst_pulse <= crst_wr;
      if (clr)             resync <= 1'b0;
      else if (resync_set) resync <= 1'b1;
      else if (resync_w1c) resync <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int unsigned WORD_W = dbgmb_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              dbg_req_valid,
  output logic              dbg_req_ready,
  input  logic [WORD_W-1:0] dbg_req_data,
  input  logic              dbg_resync,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [WORD_W-1:0] ret_data,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] dbg_status,
  output logic              chip_rst_req
);
  import dbgmb_pkg::*;

  reg_sel_e          sel;
  logic              wr_hit, rd_hit, csr_wr, soft_clr, crst_wr;
  logic              req_pop, ret_load;
  logic [WORD_W-1:0] req_word;
  logic              pending, dovr, aovr, resync;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_hit   = bus_sel & bus_wr;
  assign rd_hit   = bus_sel & ~bus_wr;
  assign csr_wr   = wr_hit && (sel == REG_CSR);
  assign soft_clr = csr_wr & bus_wdata[CSR_SRST];
  assign crst_wr  = csr_wr & bus_wdata[CSR_CRST];
  assign req_pop  = rd_hit && (sel == REG_REQ);
  assign ret_load = wr_hit && (sel == REG_RET);

  assign dbg_req_ready = 1'b1;

  dbgmb_req_slot #(.W(WORD_W)) req_i (
    .clk(clk), .rst_n(por_rst_n), .clr(soft_clr),
    .push(dbg_req_valid), .push_data(dbg_req_data), .pop(req_pop),
    .ovr_w1c(csr_wr & bus_wdata[CSR_DOVR]),
    .word(req_word), .pending(pending), .ovr(dovr)
  );

  dbgmb_ret_slot #(.W(WORD_W)) ret_i (
    .clk(clk), .rst_n(por_rst_n), .clr(soft_clr),
    .load(ret_load), .load_data(bus_wdata), .take(ret_ready),
    .ovr_w1c(csr_wr & bus_wdata[CSR_AOVR]),
    .word(ret_data), .valid(ret_valid), .ovr(aovr)
  );

  dbgmb_ctrl ctrl_i (
    .clk(clk), .rst_n(por_rst_n), .clr(soft_clr),
    .resync_set(dbg_resync), .resync_w1c(csr_wr & bus_wdata[CSR_RESYNC]),
    .crst_wr(crst_wr), .resync(resync), .crst_pulse(chip_rst_req)
  );

  logic [CSR_USED-1:0] csr_low;
  always_comb begin
    csr_low             = '0;
    csr_low[CSR_RESYNC] = resync;
    csr_low[CSR_PEND]   = pending;
    csr_low[CSR_DOVR]   = dovr;
    csr_low[CSR_AOVR]   = aovr;
  end

  generate
    if (WORD_W > CSR_USED) begin : g_pad
      assign dbg_status = {{(WORD_W-CSR_USED){1'b0}}, csr_low};
    end else begin : g_nopad
      assign dbg_status = csr_low[WORD_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      REG_REQ:  bus_rdata = req_word;
      REG_RET:  bus_rdata = ret_data;
      REG_CSR:  bus_rdata = dbg_status;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbgmb_chk.sv
module dbgmb_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              por_rst_n,
  input logic              dbg_req_valid,
  input logic              dbg_req_ready,
  input logic [WORD_W-1:0] dbg_req_data,
  input logic              dbg_resync,
  input logic              ret_valid,
  input logic              ret_ready,
  input logic [WORD_W-1:0] ret_data,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [WORD_W-1:0] dbg_status,
  input logic              chip_rst_req
);
  logic csr_w, srst, rd_req, wr_ret;
  assign csr_w  = bus_sel & bus_wr & (bus_addr == 2'd2);
  assign srst   = csr_w & bus_wdata[4];
  assign rd_req = bus_sel & ~bus_wr & (bus_addr == 2'd0);
  assign wr_ret = bus_sel & bus_wr & (bus_addr == 2'd1);

  // R1
  req_pend_set_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    dbg_req_valid && !srst |=> dbg_status[1]);

  // R2
  dbg_ovr_set_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    dbg_req_valid && dbg_status[1] && !rd_req && !srst |=> dbg_status[2]);

  // R3
  ret_hold_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    ret_valid && !ret_ready && !wr_ret && !srst |=> ret_valid && $stable(ret_data));

  // R4
  ahb_ovr_set_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    wr_ret && ret_valid && !ret_ready && !srst |=> dbg_status[3]);

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    dbg_status[2] && !srst && !(csr_w && bus_wdata[2]) |=> dbg_status[2]);

  // R7
  srst_clear_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    srst |=> (dbg_status[3:0] == 4'd0) && !ret_valid);

  // R7
  srst_reads_zero_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    bus_sel && !bus_wr && bus_addr == 2'd2 |-> !bus_rdata[4] && !bus_rdata[5]);

  // R8
  crst_pulse_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    chip_rst_req |-> $past(csr_w && bus_wdata[5]));
endmodule

bind dbg_mailbox dbgmb_chk #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/dbg_mailbox_tb_top.sv
`timescale 1ns/100ps
module dbg_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        por_rst_n;
  logic        dbg_req_valid, dbg_req_ready, dbg_resync;
  logic [31:0] dbg_req_data;
  logic        ret_valid, ret_ready;
  logic [31:0] ret_data;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, dbg_status;
  logic        chip_rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dbg_mailbox dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    tick();
    bus_sel = 0;
  endtask

  task automatic dbg_push(input logic [31:0] d);
    dbg_req_valid = 1; dbg_req_data = d;
    tick();
    dbg_req_valid = 0;
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    por_rst_n = 0; dbg_req_valid = 0; dbg_req_data = 0; dbg_resync = 0;
    ret_ready = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    #1 por_rst_n = 1;
    // R9 reset state
    check("R9 status after por", dbg_status, 32'h0);
    check("R9 ret_valid after por", {31'b0, ret_valid}, 32'h0);
    check("R1 req_ready", {31'b0, dbg_req_ready}, 32'h1);

    // R1 R2 sweep: prior pending p, new beat w, read r
    for (int c = 0; c < 8; c++) begin
      logic p, w, r;
      logic [31:0] A, B, exp_st;
      p = c[2]; w = c[1]; r = c[0];
      A = 32'hA000_0000 + c; B = 32'hB000_0000 + c;
      bus_write(2'd2, 32'h10);
      if (p) dbg_push(A);
      dbg_req_valid = w; dbg_req_data = B;
      bus_sel = r; bus_wr = 0; bus_addr = 2'd0;
      #1 rd = bus_rdata;
      if (r) check("R1 read word", rd, p ? A : 32'h0);
      tick();
      dbg_req_valid = 0; bus_sel = 0;
      exp_st = {29'b0, w & p & ~r, w | (p & ~r), 1'b0};
      check("R1 R2 status sweep", dbg_status, exp_st);
      bus_read(2'd0, rd);
      if (w) check("R2 word replaced", rd, B);
      check("R1 pending after read", {31'b0, dbg_status[1]}, 32'h0);
    end

    // R3 R4 sweep: held q, write w, ready k
    for (int c = 0; c < 8; c++) begin
      logic q, w, k;
      logic [31:0] C, D;
      q = c[2]; w = c[1]; k = c[0];
      C = 32'hC000_0000 + c; D = 32'hD000_0000 + c;
      bus_write(2'd2, 32'h10);
      if (q) bus_write(2'd1, C);
      check("R3 valid before", {31'b0, ret_valid}, {31'b0, q});
      if (q) check("R3 data held", ret_data, C);
      bus_sel = w; bus_wr = 1; bus_addr = 2'd1; bus_wdata = D; ret_ready = k;
      tick();
      bus_sel = 0; ret_ready = 0;
      check("R3 valid after", {31'b0, ret_valid}, {31'b0, w | (q & ~k)});
      check("R4 ahb overrun", {31'b0, dbg_status[3]}, {31'b0, w & q & ~k});
      if (w) check("R4 data replaced", ret_data, D);
      else if (q & ~k) check("R3 data stable", ret_data, C);
      bus_read(2'd1, rd);
      check("R10 answer readback", rd, ret_data);
    end

    // R5 W1C and set-wins race
    bus_write(2'd2, 32'h10);
    dbg_push(32'h1); dbg_push(32'h2);
    bus_write(2'd1, 32'h3); bus_write(2'd1, 32'h4);
    check("R5 both flags set", dbg_status, 32'hE);
    bus_write(2'd2, 32'h8);
    check("R5 clear ahb only", dbg_status, 32'h6);
    dbg_req_valid = 1; dbg_req_data = 32'h5;
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 32'h4;
    tick();
    dbg_req_valid = 0; bus_sel = 0;
    check("R5 set wins over clear", dbg_status, 32'h6);
    bus_write(2'd2, 32'h4);
    check("R5 clear dbg overrun", dbg_status, 32'h2);

    // R6 resync
    dbg_resync = 1; tick(); dbg_resync = 0;
    check("R6 resync set", dbg_status, 32'h3);
    bus_write(2'd2, 32'h1);
    check("R6 resync cleared", dbg_status, 32'h2);

    // R10 ignored writes
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, rd);
    check("R10 addr3 reads zero", rd, 32'h0);
    check("R10 status untouched", dbg_status, 32'h2);
    bus_read(2'd0, rd);
    check("R10 req word untouched", rd, 32'h5);

    // R8 chip reset pulse leaves state
    dbg_push(32'h77);
    bus_write(2'd2, 32'h20);
    check("R8 pulse high", {31'b0, chip_rst_req}, 32'h1);
    tick();
    check("R8 pulse one cycle", {31'b0, chip_rst_req}, 32'h0);
    check("R8 state kept", dbg_status, 32'h2);
    bus_read(2'd2, rd);
    check("R8 R7 csr reads", rd, 32'h2);

    // R7 soft reset
    bus_write(2'd1, 32'h99);
    bus_write(2'd2, 32'h10);
    check("R7 status cleared", dbg_status, 32'h0);
    check("R7 ret cleared", {31'b0, ret_valid}, 32'h0);
    bus_read(2'd0, rd);
    check("R7 req word cleared", rd, 32'h0);

    // R9 por during live state
    dbg_push(32'h55);
    por_rst_n = 0; #1;
    check("R9 async clear", dbg_status, 32'h0);
    tick(); por_rst_n = 1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule